// File: doc/BRIEF.md
# Context Tag CRC-8 Generator and Checker

This unit builds the one-byte validation tag stored with each connection context. A 24-bit context number, a 4-bit region code and a 4-bit kind code are packed into a 32-bit word. An 8-bit CRC is computed over that word in a single parallel step. The tag is formed from the CRC with its top bit forced high, and that top bit marks the tag as valid.

In the same pass the unit compares a tag read back from context memory with the freshly generated one. It also returns that stored tag with its valid bit cleared, which is the value written back to invalidate a context. A side flag reports whether the region code names one of the two aggregation regions.

Requests arrive on a valid/ready input stream, and results leave on a valid/ready output stream behind one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result is held unchanged for as long as `out_valid` is high and `out_ready` is low. A result leaves on an edge where both are high.

Top module: `ctx_tag_unit`

## Requirements
- R1: The CRC input word is formed as context number in bits [31:8], region in bits [7:4] and kind in bits [3:0].
- R2: The CRC uses generator x^8 + x^2 + x + 1 (0x07) and starts from 0xFF. It takes word bit 31 first and bit 0 last, and all 32 bits are absorbed in one step. The all-zero word gives CRC 0xD1.
- R3: The generated tag `tag_o` is 0x80 OR CRC[6:0], so bit 7 is always 1.
- R4: `match_o` is 1 exactly when `stored_tag` equals the generated tag in all 8 bits, bit 7 included.
- R5: `killed_o` equals `stored_tag` with bit 7 cleared and bits [6:0] unchanged.
- R6: `agg_o` is 1 exactly when the region code is 2 or 4.
- R7: A request accepted on a clock edge has its result on the outputs, with `out_valid` high, right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all result outputs hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: When a result is taken and no request is offered, `out_valid` goes low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| cid | input | 24 | Context number |
| region | input | 4 | Region code |
| ctype | input | 4 | Kind code |
| stored_tag | input | 8 | Tag read back from context memory |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| tag_o | output | 8 | Generated tag |
| match_o | output | 1 | Stored tag equals generated tag |
| killed_o | output | 8 | Stored tag with valid bit cleared |
| agg_o | output | 1 | Region is an aggregation region |

## Verification
The all-zero word pins the seed and generator, because its tag 0xD1 depends on nothing else. Single set bits in the kind, region and context fields, including context bit 23, show that each field lands in its own word position and that the bit order is right. Stored tags are either equal to the generated tag, equal except for bit 7, or unrelated. These tell a full 8-bit compare apart from a compare on the low seven bits only. A run of pseudo-random words covers the remaining bits against a bit-serial model, while a stall sequence and an idle drain exercise the handshake rules.

// File: rtl/ctx_tag_pkg.sv
package ctx_tag_pkg;
  localparam int TAG_W = 8;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             match;
    logic [TAG_W-1:0] killed;
    logic             agg;
  } tag_res_t;
endpackage

// File: rtl/ctx_tag_crc.sv
module ctx_tag_crc #(
  parameter int            DW   = 32,
  parameter int            CW   = 8,
  parameter logic [CW-1:0] POLY = 8'h07,
  parameter logic [CW-1:0] SEED = 8'hFF
) (
  input  logic [DW-1:0] word_i,
  output logic [CW-1:0] crc_o
);
  // bit-serial walk, used only at elaboration to derive the XOR matrix
  function automatic logic [CW-1:0] walk(input logic [DW-1:0] d, input logic [CW-1:0] s);
    logic [CW-1:0] r;
    logic          fb;
    r = s;
    for (int k = DW-1; k >= 0; k--) begin
      fb = r[CW-1] ^ d[k];
      r  = {r[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  localparam logic [CW-1:0] SEED_RESP = walk('0, SEED);

  logic [CW-1:0] term [DW];

  for (genvar j = 0; j < DW; j++) begin : g_col
    localparam logic [DW-1:0] UNIT = DW'(1) << j;
    localparam logic [CW-1:0] RESP = walk(UNIT, '0);
    assign term[j] = word_i[j] ? RESP : '0;
  end

  always_comb begin
    crc_o = SEED_RESP;
    for (int j = 0; j < DW; j++) crc_o = crc_o ^ term[j];
  end
endmodule

// File: rtl/ctx_tag_form.sv
module ctx_tag_form
  import ctx_tag_pkg::*;
#(
  parameter int FLD_W  = 4,
  parameter int AGG_LO = 2,
  parameter int AGG_HI = 4
) (
  input  logic [TAG_W-1:0] crc_i,
  input  logic [TAG_W-1:0] stored_i,
  input  logic [FLD_W-1:0] region_i,
  output tag_res_t         res_o
);
  localparam int MK = TAG_W - 1;

  logic [TAG_W-1:0] tag;

  assign tag           = {1'b1, crc_i[MK-1:0]};
  assign res_o.tag     = tag;
  assign res_o.match   = (stored_i == tag);
  assign res_o.killed  = {1'b0, stored_i[MK-1:0]};
  assign res_o.agg     = (region_i == FLD_W'(AGG_LO)) || (region_i == FLD_W'(AGG_HI));
endmodule

// File: rtl/ctx_tag_stage.sv
module ctx_tag_stage
  import ctx_tag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  tag_res_t res_i,
  output logic     out_valid,
  input  logic     out_ready,
  output tag_res_t res_o
);
  logic vld_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_o <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) res_o <= res_i;
    end
  end
endmodule

// File: rtl/ctx_tag_unit.sv
module ctx_tag_unit
  import ctx_tag_pkg::*;
#(
  parameter int CID_W = 24,
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CID_W-1:0] cid,
  input  logic [FLD_W-1:0] region,
  input  logic [FLD_W-1:0] ctype,
  input  logic [TAG_W-1:0] stored_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TAG_W-1:0] tag_o,
  output logic             match_o,
  output logic [TAG_W-1:0] killed_o,
  output logic             agg_o
);
  localparam int DW = CID_W + 2*FLD_W;

  logic [DW-1:0]    word;
  logic [TAG_W-1:0] crc;
  tag_res_t         res_d, res_q;

  // R1 packing
  assign word = {cid, region, ctype};

  ctx_tag_crc #(.DW(DW), .CW(TAG_W), .POLY(8'h07), .SEED(8'hFF)) crc_i (
    .word_i (word),
    .crc_o  (crc)
  );

  ctx_tag_form #(.FLD_W(FLD_W)) form_i (
    .crc_i    (crc),
    .stored_i (stored_tag),
    .region_i (region),
    .res_o    (res_d)
  );

  ctx_tag_stage stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_i     (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_o     (res_q)
  );

  assign tag_o    = res_q.tag;
  assign match_o  = res_q.match;
  assign killed_o = res_q.killed;
  assign agg_o    = res_q.agg;
endmodule

// File: rtl/ctx_tag_unit_chk.sv
module ctx_tag_unit_chk
  import ctx_tag_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TAG_W-1:0] tag_o,
  input logic             match_o,
  input logic [TAG_W-1:0] killed_o,
  input logic             agg_o
);
  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(tag_o) && $stable(match_o)
                                && $stable(killed_o) && $stable(agg_o));
  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R7
  accept_yields_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R3
  tag_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> tag_o[TAG_W-1]);
  // R5
  killed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !killed_o[TAG_W-1]);
  // R4
  match_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && match_o |-> killed_o == {1'b0, tag_o[TAG_W-2:0]});
  // R10
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);
endmodule

bind ctx_tag_unit ctx_tag_unit_chk chk_i (.*);

// File: tb/ctx_tag_unit_tb_top.sv
`timescale 1ns/1ps
module ctx_tag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] cid = '0;
  logic [3:0]  region = '0;
  logic [3:0]  ctype = '0;
  logic [7:0]  stored_tag = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  tag_o;
  logic        match_o;
  logic [7:0]  killed_o;
  logic        agg_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctx_tag_unit dut_i (.*);

  // {cid, region, kind, stored, expected tag, expected match}
  localparam int NV = 8;
  localparam logic [48:0] VEC [NV] = '{
    {24'h000000, 4'h0, 4'h0, 8'hD1, 8'hD1, 1'b1},
    {24'h000000, 4'h0, 4'h1, 8'hD6, 8'hD6, 1'b1},
    {24'h000001, 4'h0, 4'h0, 8'h44, 8'hC4, 1'b0},
    {24'h000000, 4'h1, 4'h0, 8'hA1, 8'hA1, 1'b1},
    {24'h000000, 4'h2, 4'h0, 8'h00, 8'hB1, 1'b0},
    {24'h000000, 4'h4, 4'h0, 8'h96, 8'h96, 1'b1},
    {24'h800000, 4'h0, 4'h0, 8'hE0, 8'hE0, 1'b1},
    {24'h800000, 4'h0, 4'h0, 8'hE1, 8'hE0, 1'b0}
  };

  function automatic logic [7:0] ref_tag(input logic [31:0] w);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 31; i >= 0; i--) begin
      if (c[7] ^ w[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return {1'b1, c[6:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] c, input logic [3:0] r, input logic [3:0] t,
                      input logic [7:0] s);
    @(negedge clk);
    cid = c; region = r; ctype = t; stored_tag = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [7:0]  et;
    logic [7:0]  st;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", 32'(out_valid), 0);
    chk("R9 in_ready after reset", 32'(in_ready), 1);

    // vector table: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][48:25], VEC[v][24:21], VEC[v][20:17], VEC[v][16:9]);
      chk("R7 out_valid after accept", 32'(out_valid), 1);
      chk("R1 R2 R3 tag", 32'(tag_o), 32'(VEC[v][8:1]));
      chk("R4 match", 32'(match_o), 32'(VEC[v][0]));
      chk("R5 killed", 32'(killed_o), 32'({1'b0, VEC[v][15:9]}));
      chk("R6 agg", 32'(agg_o),
          32'((VEC[v][24:21] == 4'd2) || (VEC[v][24:21] == 4'd4)));
    end

    // R10 idle drain: previous result taken, nothing offered
    @(negedge clk);
    chk("R10 out_valid idle", 32'(out_valid), 0);

    // pseudo-random words against serial model: R2 R4
    lcg = 32'h1234_5678;
    for (int k = 0; k < 24; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      et = ref_tag(lcg);
      st = k[0] ? et : (et ^ lcg[15:8] ^ 8'h01);
      send(lcg[31:8], lcg[7:4], lcg[3:0], st);
      chk("R2 tag random", 32'(tag_o), 32'(et));
      chk("R4 match random", 32'(match_o), 32'(st == et));
    end

    // R8 stall: hold first result, block second request
    @(negedge clk);
    out_ready = 1'b0;
    cid = 24'h000000; region = 4'h0; ctype = 4'h0; stored_tag = 8'hD1; in_valid = 1'b1;
    @(negedge clk);
    chk("R7 out_valid stall start", 32'(out_valid), 1);
    chk("R8 in_ready low", 32'(in_ready), 0);
    cid = 24'h800000; stored_tag = 8'h00;
    repeat (2) @(negedge clk);
    chk("R8 tag held", 32'(tag_o), 32'h000000D1);
    chk("R8 match held", 32'(match_o), 1);
    chk("R8 in_ready still low", 32'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second result after release", 32'(tag_o), 32'h000000E0);
    chk("R8 second match", 32'(match_o), 0);
    @(negedge clk);
    chk("R10 drained after stall", 32'(out_valid), 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule